// File: doc/BRIEF.md
# Phase-Continuous NCO Trigger Generator

This block turns a fixed system clock into a trigger train whose rate is set by a tuning word. A wide phase accumulator adds the active tuning word on every clock. Each time the sum passes full scale and wraps, the block emits a trigger pulse one clock wide. There is no sine or cosine conversion. The accumulator MSB is brought out as a 50 % square wave. The top phase bits are brought out for an optional phase-to-amplitude stage further downstream.

With the default 48-bit accumulator on a 100 MHz clock, the rate step is about 0.36 microhertz. That covers roughly 1 mHz to 15 MHz with millihertz resolution. The tuning word is double-buffered. The input word is copied into the active register only on a clock where the load strobe is high. A retune never touches the accumulator, so the change of frequency is phase-continuous: no trigger is dropped and no extra trigger appears. A word of half scale or more would alias, so it is clamped to the largest legal value and a flag is raised.

Top module: `nco_trigger_gen`

## Requirements
- R1: While rst_ni is low and after its release, with no load yet made, trig_o, square_o, phase_o and clamp_o are all 0, and the active word is 0.
- R2: On every rising clock edge, the accumulator becomes (accumulator + active word) mod 2^ACC_W.
- R3: trig_o is high for the one clock that follows each edge where the addition wrapped. After n edges from zero, the trigger count therefore equals floor(total added / 2^ACC_W), which is floor(n*W/2^ACC_W) for a constant word W.
- R4: trig_o is never high on two clocks in a row.
- R5: square_o equals accumulator bit ACC_W-1. phase_o equals accumulator bits [ACC_W-1 : ACC_W-PHASE_W].
- R6: tune_word_i is captured only on an edge where tune_load_i is 1. At any other time it has no effect on the outputs.
- R7: A load never alters the accumulator, so phase continues across a retune.
- R8: The addition on the edge that captures a new word still uses the old word. The new word is used from the next edge on.
- R9: A captured word with bit ACC_W-1 set becomes 2^(ACC_W-1)-1 and sets clamp_o to 1. A captured word below 2^(ACC_W-1) is used unchanged and sets clamp_o to 0. clamp_o changes only on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tune_word_i | input | ACC_W | Tuning word, waiting in front of the active register |
| tune_load_i | input | 1 | Strobe that moves tune_word_i into the active register |
| trig_o | output | 1 | One-clock pulse after each accumulator wrap |
| square_o | output | 1 | Accumulator MSB |
| phase_o | output | PHASE_W | Upper accumulator bits |
| clamp_o | output | 1 | Last captured word was clamped |

## Verification
A wrong accumulator value shows up at once on phase_o and square_o only if its upper bits differ. An error in the low bits stays hidden until it carries upward, and that takes many clocks when the word is small. For this reason the bench follows the exact sum of all words added since reset. It compares both the phase bits and the running trigger count against that sum at the end of each run. A lost or extra trigger at a retune changes the count for good, so the check at the end of the run catches it. A clamp fault shows on clamp_o on the clock after the load. It also makes the phase drift away from the expected value within a few clocks.

// File: rtl/nco_pkg.sv
package nco_pkg;
  parameter int unsigned ACC_W_DEF   = 48;
  parameter int unsigned PHASE_W_DEF = 12;
endpackage

// File: rtl/nco_tune_buf.sv
module nco_tune_buf #(
  parameter int unsigned ACC_W = nco_pkg::ACC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] word_i,
  input  logic             load_i,
  output logic [ACC_W-1:0] active_o,
  output logic             clamp_o
);
  localparam logic [ACC_W-1:0] WordMax = {1'b0, {(ACC_W-1){1'b1}}};

  logic             over;
  logic [ACC_W-1:0] legal;

  assign over  = word_i[ACC_W-1];
  assign legal = over ? WordMax : word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= '0;
      clamp_o  <= 1'b0;
    end else if (load_i) begin
      active_o <= legal;
      clamp_o  <= over;
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = nco_pkg::ACC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             wrap_o
);
  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc_o} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      wrap_o <= 1'b0;
    end else begin
      acc_o  <= sum[ACC_W-1:0];
      wrap_o <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/nco_trigger_gen.sv
module nco_trigger_gen #(
  parameter int unsigned ACC_W   = nco_pkg::ACC_W_DEF,
  parameter int unsigned PHASE_W = nco_pkg::PHASE_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ACC_W-1:0]   tune_word_i,
  input  logic               tune_load_i,
  output logic               trig_o,
  output logic               square_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               clamp_o
);
  logic [ACC_W-1:0] active_word;
  logic [ACC_W-1:0] acc_q;

  nco_tune_buf #(.ACC_W(ACC_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .word_i  (tune_word_i),
    .load_i  (tune_load_i),
    .active_o(active_word),
    .clamp_o (clamp_o)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(active_word),
    .acc_o (acc_q),
    .wrap_o(trig_o)
  );

  assign square_o = acc_q[ACC_W-1];
  assign phase_o  = acc_q[ACC_W-1 -: PHASE_W];
endmodule

// File: rtl/nco_trigger_chk.sv
module nco_trigger_chk #(
  parameter int unsigned ACC_W = nco_pkg::ACC_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             oversize_i,
  input logic             load_i,
  input logic             trig_i,
  input logic             clamp_i,
  input logic [ACC_W-1:0] acc_i
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R3
  wrap_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (trig_i == (acc_i < $past(acc_i))));

  // R4
  single_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !trig_i);

  // R9
  clamp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && oversize_i) |=> clamp_i);

  // R9
  clamp_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !oversize_i) |=> !clamp_i);

  // R9
  clamp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(clamp_i));
endmodule

bind nco_trigger_gen nco_trigger_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oversize_i(tune_word_i[ACC_W-1]),
  .load_i    (tune_load_i),
  .trig_i    (trig_o),
  .clamp_i   (clamp_o),
  .acc_i     (acc_q)
);

// File: tb/nco_trigger_gen_test.sv
module nco_trigger_gen_test;
  localparam int AW = 48;
  localparam int PW = 12;
  localparam int NV = 6;
  localparam logic [AW-1:0] VEC_WORD [NV] = '{
    48'h1000_0000_0000, 48'h0000_0000_0000, 48'h0000_0000_0001,
    48'h5555_5555_5555, 48'h7FFF_FFFF_FFFF, 48'h1000_0000_0001};
  localparam int VEC_CYC [NV] = '{100, 50, 40, 97, 64, 200};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] tune_word_i = '0;
  logic          tune_load_i = 1'b0;
  logic          trig_o, square_o, clamp_o;
  logic [PW-1:0] phase_o;

  int checks = 0, failures = 0, trig_cnt = 0;
  logic [95:0]   tot = '0;
  logic [AW-1:0] cur_w = '0;
  bit done = 0;

  nco_trigger_gen #(.ACC_W(AW), .PHASE_W(PW)) uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; tune_load_i = 1'b0;
    tot = '0; cur_w = '0; trig_cnt = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    tot = tot + {48'd0, cur_w};
    trig_cnt += int'(trig_o);
  endtask

  task automatic load(input logic [AW-1:0] w);
    tune_word_i = w; tune_load_i = 1'b1;
    step();  // R8: this edge still adds old word
    tune_load_i = 1'b0;
    cur_w = w[AW-1] ? {1'b0, {(AW-1){1'b1}}} : w;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check_state(input string tag);
    check({tag, " R2 R5 phase"}, 64'(phase_o), 64'(tot[AW-1 -: PW]));
    check({tag, " R5 square"}, 64'(square_o), 64'(tot[AW-1]));
    check({tag, " R3 trig count"}, 64'(trig_cnt), 64'(tot[95:AW]));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #5;
    check("R1 trig in reset", 64'(trig_o), 0);
    check("R1 phase in reset", 64'(phase_o), 0);
    do_reset();
    run(5);
    check("R1 trig after release", 64'(trig_o), 0);
    check("R1 phase after release", 64'(phase_o), 0);
    check("R1 clamp", 64'(clamp_o), 0);

    // vector table: R2 R3 R5
    for (int v = 0; v < NV; v++) begin
      do_reset();
      load(VEC_WORD[v]);
      run(VEC_CYC[v]);
      check_state($sformatf("vec%0d", v));
    end

    // R6: input word ignored without strobe
    do_reset();
    load(48'h0800_0000_0123);
    tune_word_i = 48'h7000_0000_0000;
    run(40);
    check_state("R6 ignore");

    // R7 R8: retune keeps phase
    do_reset();
    load(48'h1000_0000_0003);
    run(37);
    load(48'h0800_0000_0309);
    run(53);
    check_state("R7 R8 retune");
    load(48'h3000_0000_0000);
    run(11);
    check_state("R7 second retune");

    // R9: clamp at and above half scale
    do_reset();
    load(48'h8000_0000_0000);
    check("R9 clamp set", 64'(clamp_o), 1);
    run(30);
    check_state("R9 clamped rate");
    check("R9 clamp held", 64'(clamp_o), 1);
    load(48'h7FFF_FFFF_FFFF);
    check("R9 clamp clear at max legal", 64'(clamp_o), 0);
    run(9);
    load(48'hFFFF_FFFF_FFFF);
    check("R9 clamp set all ones", 64'(clamp_o), 1);
    run(21);
    check_state("R9 R4 max rate");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule